// File: doc/BRIEF.md
# Memory-Mapped Bus Address Decoder

This block sits between a small processor's 16-bit address bus and the devices on it. Each cycle it decides which one of five targets owns the current address: working RAM, a bank of general-purpose I/O registers, a sound controller, a video controller and ROM. It raises that target's chip select, forwards a write enable when a write is legal, and steers the chosen target's read data back onto the processor's read bus. The decode is combinational, so selects and read data follow the address in the same cycle. The memories and the GPIO and sound peripherals live outside the block. Only their select, write-enable and read-data connections appear here.

A build-time parameter picks how many address lines are compared. With full decoding every line is checked, and each location has exactly one address. With partial decoding only the upper lines needed to tell the targets apart are checked, so registers repeat at aliased addresses. A separate I/O-space strobe moves an access out of the memory map altogether. The video controller's small register file is held inside the block, and one of its registers drives the screen background colour.

The bus has no back-pressure. Every valid access completes in the cycle it is presented, so there is no ready signal. Reads need no handshake, and writes take effect on the next rising clock edge.

Top module: `mmio_decoder`

## Requirements
- R1: With full decoding, addresses 0x0000–0x7FFF select RAM (dev_sel bit 0) and 0xC000–0xFFFF select ROM (dev_sel bit 4).
- R2: With full decoding, 0x8000–0x80FF selects GPIO (bit 1), 0x9000–0x90FF selects sound (bit 2) and 0xA000–0xA7FF selects video (bit 3).
- R3: With full decoding, addresses in 0x8100–0x8FFF, 0x9100–0x9FFF and 0xA800–0xBFFF assert no select.
- R4: With partial decoding, RAM is chosen by address bit 15 low, GPIO/sound/video by the top nibble being 0x8/0x9/0xA, and ROM by the top two bits both high. Addresses 0xB000–0xBFFF select nothing.
- R5: At most one select is high in any cycle, and none is high while bus_valid is low.
- R6: A valid access with bus_io high raises io_sel, raises no memory select, returns io_rdata on bus_rdata, and raises io_we only if it is a write.
- R7: For a memory read, bus_rdata equals the read-data input of the selected target. For video, it is the internal register addressed.
- R8: A memory read that selects nothing returns 0xFF, and dec_err is high during the following cycle only for that access.
- R9: mem_we is high only for a valid memory write that selects RAM, GPIO, sound or video. Writes to ROM or to unmapped addresses never raise it.
- R10: The video block holds 8 byte registers at offsets 0–7 of its window. They reset to 0x00 and load bus_wdata on the rising edge of a valid write. Register 3 drives bg_colour.
- R11: With full decoding, video offsets 8 and above read 0x00 and writes to them change no register. With partial decoding, the register index is address bits 2:0 anywhere in 0xA000–0xAFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access present this cycle |
| bus_io | input | 1 | Access targets the separate I/O space |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data steered back to the processor |
| dev_sel | output | 5 | One-hot selects {ROM, video, sound, GPIO, RAM} |
| mem_we | output | 1 | Write enable passed to the selected memory target |
| io_sel | output | 1 | I/O-space access strobe |
| io_we | output | 1 | I/O-space write enable |
| ram_rdata | input | 8 | RAM read data |
| gpio_rdata | input | 8 | GPIO read data |
| snd_rdata | input | 8 | Sound controller read data |
| rom_rdata | input | 8 | ROM read data |
| io_rdata | input | 8 | I/O-space read data |
| dec_err | output | 1 | One-cycle pulse after an unmapped memory read |
| bg_colour | output | 8 | Background colour from video register 3 |

## Verification
A wrong mask or base in the decoder appears at once as a wrong or missing dev_sel bit and as foreign data on bus_rdata in the same cycle. The bench therefore probes both edges of every region and every gap, in both decoding variants side by side. A corrupted video register stays hidden until it is read back or until it is register 3, which shows on bg_colour one edge after the write. The bench reads back each register it writes and checks bg_colour after every access. A stuck error flag shows one cycle late, so the bench checks dec_err after the edge that follows each access.

// File: rtl/mmio_dec_pkg.sv
package mmio_dec_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int NUM_TGT  = 5;
  localparam int VID_OFF_W = 11;   // 2 KiB video window

  // target index = bit position in dev_sel
  localparam int T_RAM  = 0;
  localparam int T_GPIO = 1;
  localparam int T_SND  = 2;
  localparam int T_VID  = 3;
  localparam int T_ROM  = 4;

  localparam logic [ADDR_W-1:0] TGT_BASE [NUM_TGT] =
    '{16'h0000, 16'h8000, 16'h9000, 16'hA000, 16'hC000};
  // lines compared when every line of the region is decoded
  localparam logic [ADDR_W-1:0] TGT_FULL_MASK [NUM_TGT] =
    '{16'h8000, 16'hFF00, 16'hFF00, 16'hF800, 16'hC000};
  // lines compared when only device-picking lines are decoded
  localparam logic [ADDR_W-1:0] TGT_PART_MASK [NUM_TGT] =
    '{16'h8000, 16'hF000, 16'hF000, 16'hF000, 16'hC000};
endpackage

// File: rtl/mmio_addr_decode.sv
module mmio_addr_decode
  import mmio_dec_pkg::*;
#(
  parameter bit FULL_DECODE = 1'b1
) (
  input  logic              valid,
  input  logic              io,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_TGT-1:0] sel
);
  logic [NUM_TGT-1:0] hit;

  for (genvar i = 0; i < NUM_TGT; i++) begin : g_tgt
    localparam logic [ADDR_W-1:0] CMP_MASK =
      FULL_DECODE ? TGT_FULL_MASK[i] : TGT_PART_MASK[i];
    assign hit[i] = ((addr & CMP_MASK) == (TGT_BASE[i] & CMP_MASK));
  end

  assign sel = (valid && !io) ? hit : '0;
endmodule

// File: rtl/mmio_rdata_mux.sv
module mmio_rdata_mux
  import mmio_dec_pkg::*;
(
  input  logic [NUM_TGT-1:0]        sel,
  input  logic                      io_act,
  input  logic [NUM_TGT*DATA_W-1:0] tgt_rdata,
  input  logic [DATA_W-1:0]         io_rdata,
  output logic [DATA_W-1:0]         rdata
);
  always_comb begin
    rdata = '1;                     // unmapped reads float high
    if (io_act) begin
      rdata = io_rdata;
    end else begin
      for (int i = 0; i < NUM_TGT; i++) begin
        if (sel[i]) rdata = tgt_rdata[i*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/mmio_vid_regs.sv
module mmio_vid_regs
  import mmio_dec_pkg::*;
#(
  parameter bit FULL_DECODE = 1'b1,
  parameter int NREG        = 8,
  parameter int BG_IDX      = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel,
  input  logic                 we,
  input  logic [VID_OFF_W-1:0] off,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic [DATA_W-1:0]    bg
);
  localparam int IW = $clog2(NREG);
  localparam logic [VID_OFF_W-IW-1:0] HI_MASK = FULL_DECODE ? '1 : '0;

  logic [DATA_W-1:0] regs [NREG];
  logic [IW-1:0]     idx;
  logic              in_range;
  logic              wr;

  assign idx      = off[IW-1:0];
  assign in_range = ~|(off[VID_OFF_W-1:IW] & HI_MASK);
  assign wr       = sel && we && in_range;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        regs[r] <= '0;
      else if (wr && idx == IW'(r))      regs[r] <= wdata;
    end
  end

  assign rdata = in_range ? regs[idx] : '0;
  assign bg    = regs[BG_IDX];

  // R10
  bg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && we) |=> $stable(bg));
endmodule

// File: rtl/mmio_decoder.sv
module mmio_decoder
  import mmio_dec_pkg::*;
#(
  parameter bit FULL_DECODE = 1'b1,
  parameter int VID_NREG    = 8,
  parameter int VID_BG_IDX  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_io,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [NUM_TGT-1:0] dev_sel,
  output logic               mem_we,
  output logic               io_sel,
  output logic               io_we,
  input  logic [DATA_W-1:0]  ram_rdata,
  input  logic [DATA_W-1:0]  gpio_rdata,
  input  logic [DATA_W-1:0]  snd_rdata,
  input  logic [DATA_W-1:0]  rom_rdata,
  input  logic [DATA_W-1:0]  io_rdata,
  output logic               dec_err,
  output logic [DATA_W-1:0]  bg_colour
);
  logic [DATA_W-1:0]         vid_rdata;
  logic [NUM_TGT*DATA_W-1:0] tgt_rdata;
  logic                      io_act;
  logic                      miss_rd;

  assign io_act = bus_valid && bus_io;

  mmio_addr_decode #(.FULL_DECODE(FULL_DECODE)) u_dec (
    .valid (bus_valid),
    .io    (bus_io),
    .addr  (bus_addr),
    .sel   (dev_sel)
  );

  mmio_vid_regs #(
    .FULL_DECODE (FULL_DECODE),
    .NREG        (VID_NREG),
    .BG_IDX      (VID_BG_IDX)
  ) u_vid (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (dev_sel[T_VID]),
    .we    (bus_we),
    .off   (bus_addr[VID_OFF_W-1:0]),
    .wdata (bus_wdata),
    .rdata (vid_rdata),
    .bg    (bg_colour)
  );

  assign tgt_rdata = {rom_rdata, vid_rdata, snd_rdata, gpio_rdata, ram_rdata};

  mmio_rdata_mux u_mux (
    .sel       (dev_sel),
    .io_act    (io_act),
    .tgt_rdata (tgt_rdata),
    .io_rdata  (io_rdata),
    .rdata     (bus_rdata)
  );

  assign mem_we = bus_valid && bus_we && !bus_io && (|dev_sel) && !dev_sel[T_ROM];
  assign io_sel = io_act;
  assign io_we  = io_act && bus_we;

  assign miss_rd = bus_valid && !bus_io && !bus_we && (dev_sel == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dec_err <= 1'b0;
    else        dec_err <= miss_rd;
  end

  // R5
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_sel));
  // R5
  idle_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> dev_sel == '0);
  // R6
  io_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_io) |-> (dev_sel == '0 && bus_rdata == io_rdata));
  // R9
  rom_nowe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_sel[T_ROM] |-> !mem_we);
  // R8
  miss_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_io && !bus_we && dev_sel == '0) |-> bus_rdata == 8'hFF);
  // R1
  ram_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_sel[T_RAM] |-> !bus_addr[ADDR_W-1]);
endmodule

// File: tb/sim_mmio_decoder.sv
`timescale 1ns/1ps
module sim_mmio_decoder;
  localparam logic [7:0] RAM_D = 8'h11, GPIO_D = 8'h22, SND_D = 8'h33,
                         ROM_D = 8'h44, IO_D = 8'h55;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_io = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;

  logic [7:0] rd_w [2];
  logic [4:0] sel_w [2];
  logic       mwe_w [2], ios_w [2], iow_w [2], err_w [2];
  logic [7:0] bg_w [2];

  always #2 clk = ~clk;

  mmio_decoder #(.FULL_DECODE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_io(bus_io),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd_w[0]), .dev_sel(sel_w[0]), .mem_we(mwe_w[0]),
    .io_sel(ios_w[0]), .io_we(iow_w[0]), .ram_rdata(RAM_D),
    .gpio_rdata(GPIO_D), .snd_rdata(SND_D), .rom_rdata(ROM_D),
    .io_rdata(IO_D), .dec_err(err_w[0]), .bg_colour(bg_w[0]));

  mmio_decoder #(.FULL_DECODE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_io(bus_io),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd_w[1]), .dev_sel(sel_w[1]), .mem_we(mwe_w[1]),
    .io_sel(ios_w[1]), .io_we(iow_w[1]), .ram_rdata(RAM_D),
    .gpio_rdata(GPIO_D), .snd_rdata(SND_D), .rom_rdata(ROM_D),
    .io_rdata(IO_D), .dec_err(err_w[1]), .bg_colour(bg_w[1]));

  typedef struct packed {
    logic       dut;
    logic       post;
    logic [4:0] sel;
    logic       mwe, ios, iow;
    logic [7:0] rd;
    logic       err;
    logic [7:0] bg;
  } item_t;

  item_t exp_q[$];
  string tag_q[$];
  event  chk_ev;
  int n_chk = 0, n_bad = 0;
  logic [7:0] vreg [2][8];

  // reference map, written from the requirements
  function automatic logic [4:0] m_sel(int d, logic v, logic io, logic [15:0] a);
    if (!v || io) return 5'b0;
    if (d == 0) begin
      if (a <= 16'h7FFF) return 5'b00001;
      if (a >= 16'h8000 && a <= 16'h80FF) return 5'b00010;
      if (a >= 16'h9000 && a <= 16'h90FF) return 5'b00100;
      if (a >= 16'hA000 && a <= 16'hA7FF) return 5'b01000;
      if (a >= 16'hC000) return 5'b10000;
      return 5'b0;
    end
    if (!a[15]) return 5'b00001;
    if (a[15:12] == 4'h8) return 5'b00010;
    if (a[15:12] == 4'h9) return 5'b00100;
    if (a[15:12] == 4'hA) return 5'b01000;
    if (a[15:14] == 2'b11) return 5'b10000;
    return 5'b0;
  endfunction

  function automatic logic vid_in(int d, logic [15:0] a);
    return (d == 1) || (a[10:3] == 8'h00);
  endfunction

  // monitor: pops expectations and compares with the ports
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        item_t e; string t; int d; logic ok;
        e = exp_q.pop_front(); t = tag_q.pop_front(); d = int'(e.dut);
        n_chk++;
        if (!e.post)
          ok = (sel_w[d] === e.sel) && (mwe_w[d] === e.mwe) && (ios_w[d] === e.ios)
               && (iow_w[d] === e.iow) && (rd_w[d] === e.rd);
        else
          ok = (err_w[d] === e.err) && (bg_w[d] === e.bg);
        if (!ok) begin
          n_bad++;
          if (!e.post)
            $display("FAIL %s dut%0d: sel=%b mwe=%b ios=%b iow=%b rd=%h expected sel=%b mwe=%b ios=%b iow=%b rd=%h",
              t, d, sel_w[d], mwe_w[d], ios_w[d], iow_w[d], rd_w[d],
              e.sel, e.mwe, e.ios, e.iow, e.rd);
          else
            $display("FAIL %s dut%0d: err=%b bg=%h expected err=%b bg=%h",
              t, d, err_w[d], bg_w[d], e.err, e.bg);
        end
      end
    end
  end

  // driver: applies one access and pushes what both variants must show
  task automatic apply(input logic v, input logic io, input logic we,
                       input logic [15:0] a, input logic [7:0] wd, input string t);
    @(negedge clk);
    bus_valid = v; bus_io = io; bus_we = we; bus_addr = a; bus_wdata = wd;
    #0.5;
    for (int d = 0; d < 2; d++) begin
      item_t e;
      e = '0; e.dut = d[0]; e.post = 1'b0;
      e.sel = m_sel(d, v, io, a);
      e.ios = v && io;
      e.iow = v && io && we;
      e.mwe = v && we && !io && (e.sel != 0) && !e.sel[4];
      if (v && io) e.rd = IO_D;
      else case (e.sel)
        5'b00001: e.rd = RAM_D;
        5'b00010: e.rd = GPIO_D;
        5'b00100: e.rd = SND_D;
        5'b01000: e.rd = vid_in(d, a) ? vreg[d][a[2:0]] : 8'h00;
        5'b10000: e.rd = ROM_D;
        default:  e.rd = 8'hFF;
      endcase
      exp_q.push_back(e); tag_q.push_back(t);
    end
    ->chk_ev;
    @(posedge clk);
    #0.5;
    for (int d = 0; d < 2; d++) begin
      item_t e; logic [4:0] s;
      s = m_sel(d, v, io, a);
      if (s == 5'b01000 && we && vid_in(d, a)) vreg[d][a[2:0]] = wd;
      e = '0; e.dut = d[0]; e.post = 1'b1;
      e.err = v && !io && !we && (s == 0);
      e.bg  = vreg[d][3];
      exp_q.push_back(e); tag_q.push_back(t);
    end
    ->chk_ev;
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int d = 0; d < 2; d++)
      for (int r = 0; r < 8; r++) vreg[d][r] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // reset state, idle bus
    apply(0, 0, 0, 16'h0000, 8'h00, "R5 idle/reset");
    apply(0, 0, 1, 16'hA003, 8'hEE, "R5 invalid write ignored");
    // R1 RAM and ROM edges
    apply(1, 0, 0, 16'h0000, 0, "R1 ram low");
    apply(1, 0, 0, 16'h7FFF, 0, "R1 ram high");
    apply(1, 0, 0, 16'hC000, 0, "R1 rom low");
    apply(1, 0, 0, 16'hFFFF, 0, "R1 rom high");
    // R2 peripheral windows
    apply(1, 0, 0, 16'h8000, 0, "R2 gpio low");
    apply(1, 0, 0, 16'h80FF, 0, "R2 gpio high");
    apply(1, 0, 0, 16'h9000, 0, "R2 snd low");
    apply(1, 0, 0, 16'h90FF, 0, "R2 snd high");
    apply(1, 0, 0, 16'hA000, 0, "R2 vid low");
    apply(1, 0, 0, 16'hA7FF, 0, "R2 vid high");
    // R3 gaps (R4 aliases on the partial variant)
    apply(1, 0, 0, 16'h8100, 0, "R3 gap gpio/R4");
    apply(1, 0, 0, 16'h8FFF, 0, "R3 gap gpio end/R4");
    apply(1, 0, 0, 16'h9100, 0, "R3 gap snd/R4");
    apply(1, 0, 0, 16'h9FFF, 0, "R3 gap snd end/R4");
    apply(1, 0, 0, 16'hA800, 0, "R3 gap vid/R4");
    apply(1, 0, 0, 16'hBFFF, 0, "R3 gap top R8");
    // R8 error pulse is one cycle
    apply(1, 0, 0, 16'hB000, 0, "R8 unmapped read");
    apply(1, 0, 0, 16'h1234, 0, "R8 err falls");
    apply(1, 0, 1, 16'hB000, 8'h12, "R8 unmapped write no err R9");
    // R6 I/O space
    apply(1, 1, 0, 16'h0010, 0, "R6 io read");
    apply(1, 1, 1, 16'h8000, 8'h99, "R6 io write");
    apply(1, 1, 0, 16'hB000, 0, "R6 io no err");
    // R9 write gating
    apply(1, 0, 1, 16'hC123, 8'h01, "R9 rom write dropped");
    apply(1, 0, 1, 16'h4000, 8'h02, "R9 ram write");
    apply(1, 0, 1, 16'h8500, 8'h03, "R9 gap write/R4 alias");
    // R10 video registers and background
    apply(1, 0, 1, 16'hA003, 8'h5A, "R10 bg write");
    apply(1, 0, 0, 16'hA003, 0, "R10 bg readback R7");
    apply(1, 0, 1, 16'hA000, 8'hC1, "R10 reg0 write");
    apply(1, 0, 1, 16'hA007, 8'h7E, "R10 reg7 write");
    apply(1, 0, 0, 16'hA000, 0, "R10 reg0 read R7");
    apply(1, 0, 0, 16'hA007, 0, "R10 reg7 read");
    // R11 out-of-range vs alias
    apply(1, 0, 1, 16'hA00B, 8'h77, "R11 offset 0xB write");
    apply(1, 0, 0, 16'hA003, 0, "R11 reg3 after alias write");
    apply(1, 0, 0, 16'hA00F, 0, "R11 offset 0xF read");
    apply(1, 0, 1, 16'hA7F8, 8'h3C, "R11 far write");
    apply(1, 0, 0, 16'hA000, 0, "R11 reg0 after far write");
    apply(1, 0, 1, 16'hAFFB, 8'h6D, "R11 partial alias write/R3");
    apply(1, 0, 0, 16'hA003, 0, "R11 reg3 final");
    apply(0, 0, 0, 16'h0000, 0, "R5 idle end");
    #10;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule